// File: doc/BRIEF.md
# Row Accumulation Engine with Interleaved Partial Sums

This block produces one row of a signed integer matrix product, C[j] = sum over k of A[k]*B[k][j]. It holds every partial sum of the row in a local register array, so no partial result leaves the block until the whole reduction is complete. It is used once per output row: a start pulse launches it, the source streams the B elements of the row, and the block streams back the finished results.

The loop order is swapped relative to a plain dot product. The reduction step k is the slow index and the column j is the fast index, so consecutive accepted elements update different accumulators. Each accumulator is read when its product is issued and written back L cycles later through a short pipeline. Because a column comes round again only after N accepted elements, the sum never depends on its own unfinished update.

The block runs in four phases. First it clears all N accumulators, one per cycle. Next it accepts K*N products, then waits for the pipeline to drain. Then it emits the N sums in column order under backpressure. A one-cycle done pulse closes the row.

Top module: `rowacc_top`

## Requirements
- R1: After reset the block is idle: `b_ready_o`, `c_valid_o` and `done_o` are all low.
- R2: A `start_i` pulse while idle begins a row. A `start_i` pulse while a row is in progress is ignored and does not change the row's results.
- R3: After a start, the block clears the N accumulators over exactly N cycles with `b_ready_o` low. `b_ready_o` first rises N cycles after the cycle in which start was taken. Sums left over from an earlier row never reach a later row's results.
- R4: Accepted elements are ordered with k outer and j inner: the m-th accepted element is B[k][j] with m = k*N + j, and `a_i` carries A[k] alongside it. The result for column j is the two's-complement signed sum over k of A[k]*B[k][j], computed at a width of 2*W + ceil(log2 K) bits.
- R5: An element is consumed only on a cycle where `b_valid_i` and `b_ready_o` are both high. Idle cycles in the input stream do not alter the results. `b_ready_o` falls after K*N elements have been taken.
- R6: Output begins only after the last accumulator update has landed. Exactly N results leave the block, in ascending column order, one per cycle in which `c_valid_o` and `c_ready_i` are both high.
- R7: While `c_valid_o` is high and `c_ready_i` is low, `c_valid_o` stays high and `c_data_o` holds its value.
- R8: `done_o` is high for exactly one cycle, the cycle after the final output handshake. The block is idle afterwards.
- R9: Full-scale negative inputs in every position (-2^(W-1) times -2^(W-1), K times) yield K*2^(2W-2) without overflow. The mixed extreme case gives the exact negative sum.
- R10: Elaboration rejects N <= L. While accumulating, the pipeline never writes the column being read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a row when idle |
| a_i | input | W | Signed A element of the current reduction step |
| b_valid_i | input | 1 | B element present |
| b_data_i | input | W | Signed B element |
| b_ready_o | output | 1 | Block accepts a B element |
| c_valid_o | output | 1 | Result element present |
| c_ready_i | input | 1 | Sink takes the result element |
| c_data_o | output | 2*W+clog2(K) | Signed finished sum for the current column |
| done_o | output | 1 | One-cycle end-of-row pulse |

## Verification
The assertions assume the source keeps `a_i` equal to A[k] for the element being offered. They also assume the sink eventually raises `c_ready_i`; without that, the hold check could stall forever, though it would not fire falsely. The stimulus builds every offered element from its k and j indices, so `a_i` always matches the element. Every sink pattern raises ready at least every other cycle. Input gaps, output stalls and a stray start in mid-row are placed on fixed cycle patterns, so the pipeline hazard check is exercised while accepted elements arrive unevenly.

// File: rtl/rowacc_pkg.sv
package rowacc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_ACCUM = 3'd2,
    ST_WBACK = 3'd3,
    ST_DONE  = 3'd4
  } rowacc_state_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rowacc_ctrl.sv
module rowacc_ctrl
  import rowacc_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4,
  localparam int IW = idx_w(N),
  localparam int KW = idx_w(K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          b_valid_i,
  input  logic          pipe_busy_i,
  input  logic          c_ready_i,
  output logic          b_ready_o,
  output logic          accept_o,
  output logic [IW-1:0] col_o,
  output logic [IW-1:0] idx_o,
  output logic          init_we_o,
  output logic          c_valid_o,
  output logic          done_o
);

  rowacc_state_e state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] col_q, col_d;
  logic [KW-1:0] red_q, red_d;
  logic          all_in_q, all_in_d;

  assign b_ready_o = (state_q == ST_ACCUM) && !all_in_q;
  assign accept_o  = b_ready_o && b_valid_i;
  assign col_o     = col_q;
  assign idx_o     = idx_q;
  assign init_we_o = (state_q == ST_INIT);
  assign c_valid_o = (state_q == ST_WBACK);
  assign done_o    = (state_q == ST_DONE);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    col_d    = col_q;
    red_d    = red_q;
    all_in_d = all_in_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_INIT;
          idx_d   = '0;
        end
      end
      ST_INIT: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IW'(N - 1)) begin
          state_d  = ST_ACCUM;
          idx_d    = '0;
          col_d    = '0;
          red_d    = '0;
          all_in_d = 1'b0;
        end
      end
      ST_ACCUM: begin
        if (accept_o) begin
          if (col_q == IW'(N - 1)) begin
            col_d = '0;
            if (red_q == KW'(K - 1)) all_in_d = 1'b1;
            else                     red_d    = red_q + 1'b1;
          end else begin
            col_d = col_q + 1'b1;
          end
        end
        if (all_in_q && !pipe_busy_i) begin
          state_d = ST_WBACK;
          idx_d   = '0;
        end
      end
      ST_WBACK: begin
        if (c_ready_i) begin
          if (idx_q == IW'(N - 1)) state_d = ST_DONE;
          else                     idx_d   = idx_q + 1'b1;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      col_q    <= '0;
      red_q    <= '0;
      all_in_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      col_q    <= col_d;
      red_q    <= red_d;
      all_in_q <= all_in_d;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(c_valid_o && c_ready_i));

endmodule

// File: rtl/rowacc_mac_pipe.sv
module rowacc_mac_pipe #(
  parameter int W  = 8,
  parameter int L  = 2,
  parameter int AW = 18,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [IW-1:0] col_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [AW-1:0] old_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [IW-1:0] waddr_o,
  output logic [AW-1:0] wdata_o
);

  localparam int PW = 2 * W;

  logic [L-1:0]          vld_q;
  logic [IW-1:0]         addr_q [L];
  logic signed [PW-1:0]  prod_q [L];
  logic [AW-1:0]         old_q  [L];
  logic signed [PW-1:0]  prod_new;
  logic signed [AW-1:0]  prod_ext;

  assign prod_new = $signed(a_i) * $signed(b_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= issue_i;
      for (int s = 1; s < L; s++) vld_q[s] <= vld_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (issue_i) begin
      addr_q[0] <= col_i;
      prod_q[0] <= prod_new;
      old_q[0]  <= old_i;
    end
    for (int s = 1; s < L; s++) begin
      if (vld_q[s-1]) begin
        addr_q[s] <= addr_q[s-1];
        prod_q[s] <= prod_q[s-1];
        old_q[s]  <= old_q[s-1];
      end
    end
  end

  assign prod_ext = AW'(prod_q[L-1]);
  assign busy_o   = |vld_q;
  assign we_o     = vld_q[L-1];
  assign waddr_o  = addr_q[L-1];
  assign wdata_o  = old_q[L-1] + prod_ext;

endmodule

// File: rtl/rowacc_rowbuf.sv
module rowacc_rowbuf #(
  parameter int N  = 8,
  parameter int AW = 18,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_a_i,
  output logic [AW-1:0] rdata_a_o,
  input  logic [IW-1:0] raddr_b_i,
  output logic [AW-1:0] rdata_b_o
);

  logic [AW-1:0] mem_q [N];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/rowacc_top.sv
module rowacc_top
  import rowacc_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 8,
  parameter int K = 4,
  parameter int L = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [W-1:0]               a_i,
  input  logic                       b_valid_i,
  input  logic [W-1:0]               b_data_i,
  output logic                       b_ready_o,
  output logic                       c_valid_o,
  input  logic                       c_ready_i,
  output logic [2*W+$clog2(K)-1:0]   c_data_o,
  output logic                       done_o
);

  localparam int AW = 2 * W + $clog2(K);
  localparam int IW = idx_w(N);

  // R10
  if (N <= L) begin : g_bad_depth
    $error("row length must exceed the accumulate latency");
  end

  logic          accept;
  logic [IW-1:0] col;
  logic [IW-1:0] idx;
  logic          init_we;
  logic          pipe_busy;
  logic          pipe_we;
  logic [IW-1:0] pipe_waddr;
  logic [AW-1:0] pipe_wdata;
  logic [AW-1:0] old_sum;
  logic          buf_we;
  logic [IW-1:0] buf_waddr;
  logic [AW-1:0] buf_wdata;

  rowacc_ctrl #(.N(N), .K(K)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .b_valid_i   (b_valid_i),
    .pipe_busy_i (pipe_busy),
    .c_ready_i   (c_ready_i),
    .b_ready_o   (b_ready_o),
    .accept_o    (accept),
    .col_o       (col),
    .idx_o       (idx),
    .init_we_o   (init_we),
    .c_valid_o   (c_valid_o),
    .done_o      (done_o)
  );

  rowacc_mac_pipe #(.W(W), .L(L), .AW(AW), .IW(IW)) pipe_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (accept),
    .col_i   (col),
    .a_i     (a_i),
    .b_i     (b_data_i),
    .old_i   (old_sum),
    .busy_o  (pipe_busy),
    .we_o    (pipe_we),
    .waddr_o (pipe_waddr),
    .wdata_o (pipe_wdata)
  );

  assign buf_we    = init_we | pipe_we;
  assign buf_waddr = init_we ? idx : pipe_waddr;
  assign buf_wdata = init_we ? '0  : pipe_wdata;

  rowacc_rowbuf #(.N(N), .AW(AW), .IW(IW)) rowbuf_i (
    .clk       (clk),
    .we_i      (buf_we),
    .waddr_i   (buf_waddr),
    .wdata_i   (buf_wdata),
    .raddr_a_i (col),
    .rdata_a_o (old_sum),
    .raddr_b_i (idx),
    .rdata_b_o (c_data_o)
  );

  // R10
  rmw_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_we && accept) |-> (pipe_waddr != col));

  // R6
  drain_before_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid_o |-> !pipe_busy);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid_o && !c_ready_i) |=> (c_valid_o && $stable(c_data_o)));

endmodule

// File: tb/rowacc_top_tb_top.sv
`timescale 1ns/1ps
module rowacc_top_tb_top;

  localparam int W  = 8;
  localparam int N  = 8;
  localparam int K  = 4;
  localparam int L  = 2;
  localparam int AW = 2 * W + $clog2(K);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [W-1:0]  a_i;
  logic          b_valid_i;
  logic [W-1:0]  b_data_i;
  logic          b_ready_o;
  logic          c_valid_o;
  logic          c_ready_i;
  logic [AW-1:0] c_data_o;
  logic          done_o;

  int total = 0;
  int bad   = 0;

  longint av  [K];
  longint bv  [K][N];
  longint got [N];
  longint expv[N];
  int     ngot;

  always #2 clk = ~clk;

  rowacc_top #(.W(W), .N(N), .K(K), .L(L)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .a_i       (a_i),
    .b_valid_i (b_valid_i),
    .b_data_i  (b_data_i),
    .b_ready_o (b_ready_o),
    .c_valid_o (c_valid_o),
    .c_ready_i (c_ready_i),
    .c_data_o  (c_data_o),
    .done_o    (done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_row(input int gap, input int bp, input int spur, input string tag);
    for (int j = 0; j < N; j++) begin
      expv[j] = 0;
      for (int k = 0; k < K; k++) expv[j] += av[k] * bv[k][j];
    end
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    fork
      begin : feeder
        int m = 0;
        int cyc = 0;
        int waits = 0;
        bit seen = 1'b0;
        while (m < K * N) begin
          if (!seen && !b_ready_o) waits++;
          if (b_ready_o) seen = 1'b1;
          b_valid_i = (gap != 0 && (cyc % 3 == 1)) ? 1'b0 : 1'b1;
          b_data_i  = W'(bv[m / N][m % N]);
          a_i       = W'(av[m / N]);
          start_i   = (spur != 0 && m == 3) ? 1'b1 : 1'b0;
          if (b_valid_i && b_ready_o) m++;
          cyc++;
          @(negedge clk);
        end
        b_valid_i = 1'b0;
        start_i   = 1'b0;
        // R5: ready falls once all elements are in
        chk(b_ready_o == 1'b0, "R5", b_ready_o, 0);
        // R3: clearing phase lasts N cycles
        chk(waits == N, "R3", waits, N);
      end
      begin : collector
        int cyc = 0;
        bit held = 1'b0;
        logic [AW-1:0] hold_val = '0;
        ngot = 0;
        while (ngot < N) begin
          if (held) begin
            // R7: stalled output keeps its value
            chk(c_valid_o && c_data_o == hold_val, "R7", longint'(c_data_o), longint'(hold_val));
          end
          c_ready_i = (bp != 0) ? ((cyc % 2) == 0) : 1'b1;
          held = c_valid_o && !c_ready_i;
          hold_val = c_data_o;
          if (c_valid_o && c_ready_i) begin
            got[ngot] = longint'($signed(c_data_o));
            ngot++;
          end
          cyc++;
          @(negedge clk);
        end
        c_ready_i = 1'b0;
        // R8: done pulse follows last handshake
        chk(done_o == 1'b1, "R8", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0 && c_valid_o == 1'b0, "R8", {done_o, c_valid_o}, 0);
      end
    join
    for (int j = 0; j < N; j++) begin
      // R4 R6: column order and exact sums
      chk(got[j] == expv[j], tag, got[j], expv[j]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; a_i = '0; b_valid_i = 1'b0;
    b_data_i = '0; c_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!b_ready_o && !c_valid_o && !done_o, "R1", {b_ready_o, c_valid_o, done_o}, 0);
    repeat (4) @(negedge clk);
    // R2: nothing starts without a start pulse
    chk(!b_ready_o && !c_valid_o, "R2", {b_ready_o, c_valid_o}, 0);
  endtask

  task automatic t_basic();
    for (int k = 0; k < K; k++) begin
      av[k] = k + 1;
      for (int j = 0; j < N; j++) bv[k][j] = ((k * 37 + j * 11) % 256) - 128;
    end
    run_row(0, 0, 0, "R4");
  endtask

  task automatic t_gaps_bp();
    for (int k = 0; k < K; k++) begin
      av[k] = (k % 2 == 0) ? -(k * 9 + 5) : (k * 13 + 2);
      for (int j = 0; j < N; j++) bv[k][j] = ((j * 29 + k * 7) % 200) - 100;
    end
    run_row(1, 1, 0, "R5");
  endtask

  task automatic t_extreme();
    for (int k = 0; k < K; k++) begin
      av[k] = -128;
      for (int j = 0; j < N; j++) bv[k][j] = -128;
    end
    run_row(0, 0, 0, "R9");
    for (int k = 0; k < K; k++) begin
      av[k] = -128;
      for (int j = 0; j < N; j++) bv[k][j] = (j % 2 == 0) ? 127 : -128;
    end
    run_row(1, 0, 0, "R9");
  endtask

  task automatic t_spurious_start();
    for (int k = 0; k < K; k++) begin
      av[k] = 3 - k;
      for (int j = 0; j < N; j++) bv[k][j] = j - k * 2;
    end
    run_row(0, 1, 1, "R2");
  endtask

  task automatic t_back_to_back();
    for (int k = 0; k < K; k++) begin
      av[k] = 1;
      for (int j = 0; j < N; j++) bv[k][j] = (k == 0) ? j : 0;
    end
    // R3: earlier sums must not leak into this row
    run_row(0, 0, 0, "R3");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_gaps_bp();
    t_extreme();
    t_spurious_start();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule